// File: doc/BRIEF.md
# TPM SPI Transaction Engine

This block is a SPI controller that carries out register transactions against a peripheral that can hold off the controller. A command port gives a direction, a byte count from 1 to 64, and a 24-bit register address. The engine lowers chip select and clocks out a four-byte header. It then looks at the last bit it received in the fourth header byte. If that bit is 0, the peripheral is not ready, and the engine clocks single filler bytes, checking the last bit of each one, until the peripheral signals that it is ready. Only then do the data bytes move.

Write data comes in on a valid/ready byte stream and read data goes out on another. A divider input sets the serial clock rate. A limit input caps the number of filler bytes. If the peripheral is still not ready when that limit is reached, the transaction is abandoned and reported with an error flag.

Top module: `tpm_spi_xact`

## Requirements
- R1: The header is four bytes, sent MSB first with SPI mode 0 (MOSI changes on the falling SCLK edge and is sampled on the rising edge). In byte one, bit 7 is 1 for a read and 0 for a write, bit 6 is 0, and bits 5:0 hold the count minus one. Bytes two to four carry the address, most significant byte first.
- R2: If the last bit received in the fourth header byte is 1, the data bytes follow the header directly, with no filler byte.
- R3: If that bit is 0, the engine clocks filler bytes of 0x00, one at a time. It goes to the data phase after the first filler byte whose last received bit is 1.
- R4: One SCLK period lasts clk_div+1 clock cycles. Within a period, SCLK is low for floor((clk_div+2)/2) cycles and high for the remaining cycles. A clk_div of 0 behaves as 1.
- R5: spi_cs_n goes low when a command is accepted and stays low through the header, filler and data bytes. It rises exactly once, at the end of the transaction. cmd_ready is high only while the engine is idle.
- R6: A write takes exactly count bytes from the write stream and sends them in the order received.
- R7: A read delivers exactly count bytes, in the order received. Each byte is held until rd_ready takes it. MOSI is 0x00 during read data. done comes only after the last byte has been taken.
- R8: At most wait_limit filler bytes are clocked. If the peripheral still signals "not ready" after that many, chip select rises, done and error are raised together, and no data moves. With a limit of 0, a "not ready" in the header aborts the transaction at once.
- R9: done is a single-cycle pulse at the end of every transaction. error is raised only with done, and only on an abort.
- R10: After reset, spi_cs_n is high, SCLK is low, cmd_ready is high, and done, error, rd_valid and wr_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Serial clock divider (period is clk_div+1 cycles) |
| wait_limit | input | TMO_W | Maximum number of filler bytes |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_read | input | 1 | 1 for read, 0 for write |
| cmd_len_m1 | input | 6 | Byte count minus one |
| cmd_addr | input | 24 | Register address |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Controller data out |
| spi_miso | input | 1 | Peripheral data in |
| done | output | 1 | Transaction end pulse |
| error | output | 1 | Abort flag, valid with done |

## Verification
The hardest case to reach is a peripheral that stays "not ready" for exactly as many filler bytes as the limit allows, and also for one byte more. These two cases sit on either side of the abort decision. A bench peripheral model produces its MISO stream from a per-transaction stall count, so the table can place that count just at the limit and just past it. Read back-pressure is applied in the same run to stretch the data phase. A zero limit and a zero divider cover the two degenerate settings.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HDR, ST_POLL, ST_DATA, ST_FINISH, ST_ABORT
  } xact_state_t;

  // Header byte k of a transaction, k = 0..3
  function automatic logic [7:0] hdr_byte(input logic rd,
                                          input logic [LEN_W-1:0] lm1,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic [1:0] k);
    case (k)
      2'd0:    hdr_byte = {rd, 1'b0, lm1};
      2'd1:    hdr_byte = addr[23:16];
      2'd2:    hdr_byte = addr[15:8];
      default: hdr_byte = addr[7:0];
    endcase
  endfunction
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             byte_done,
  output logic [7:0]       rx_byte
);
  logic             active;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitcnt;
  logic [7:0]       tx_q;
  logic [7:0]       rx_q;
  logic             done_q;
  logic [DIV_W-1:0] div_e;
  logic [DIV_W-1:0] half;
  logic             bit_end;
  logic             rise_evt;

  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
    clamp_div = (d == '0) ? DIV_W'(1) : d;
  endfunction

  function automatic logic [DIV_W-1:0] low_len(input logic [DIV_W-1:0] de);
    logic [DIV_W:0] w;
    w = ({1'b0, de} + (DIV_W+1)'(2)) >> 1;
    low_len = w[DIV_W-1:0];
  endfunction

  assign div_e    = clamp_div(div);
  assign half     = low_len(div_e);
  assign bit_end  = active && (cnt == div_e);
  assign rise_evt = active && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      bitcnt <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cnt    <= '0;
          bitcnt <= '0;
          tx_q   <= tx_byte;
        end
      end else begin
        if (rise_evt) rx_q <= {rx_q[6:0], miso};
        if (bit_end) begin
          cnt <= '0;
          if (bitcnt == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 3'd1;
            tx_q   <= {tx_q[6:0], 1'b0};
          end
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end

  assign busy      = active;
  assign sclk      = active && (cnt >= half);
  assign mosi      = tx_q[7];
  assign byte_done = done_q;
  assign rx_byte   = rx_q;

  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
  // R4
  done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !sclk);
endmodule

// File: rtl/spi_wait_budget.sv
module spi_wait_budget #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [TMO_W-1:0] limit,
  output logic             exhausted
);
  logic [TMO_W-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     used <= '0;
    else if (clear) used <= '0;
    else if (bump)  used <= used + TMO_W'(1);
  end

  assign exhausted = (used >= limit);

  // R8
  bump_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> !exhausted);
endmodule

// File: rtl/tpm_spi_xact.sv
module tpm_spi_xact
  import tpm_spi_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [TMO_W-1:0] wait_limit,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_read,
  input  logic [5:0]       cmd_len_m1,
  input  logic [23:0]      cmd_addr,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             done,
  output logic             error
);
  xact_state_t       state;
  logic              cs_n_q;
  logic              armed;
  logic [LEN_W-1:0]  idx;
  logic              lat_rd;
  logic [LEN_W-1:0]  lat_lm1;
  logic [ADDR_W-1:0] lat_addr;
  logic              rd_valid_q;
  logic [7:0]        rd_data_q;
  logic              done_q;
  logic              err_q;

  logic              eng_busy;
  logic              eng_done;
  logic [7:0]        eng_rx;
  logic              can_go;
  logic [7:0]        tx_sel;
  logic              accept;
  logic              decide;
  logic              wait_seen;
  logic              exhausted;
  logic              bump;

  assign accept = (state == ST_IDLE) && cmd_valid;

  always_comb begin
    case (state)
      ST_HDR:  tx_sel = hdr_byte(lat_rd, lat_lm1, lat_addr, idx[1:0]);
      ST_DATA: tx_sel = lat_rd ? 8'h00 : wr_data;
      default: tx_sel = 8'h00;
    endcase
  end

  always_comb begin
    can_go = 1'b0;
    if (armed && !eng_busy) begin
      case (state)
        ST_HDR, ST_POLL: can_go = 1'b1;
        ST_DATA:         can_go = lat_rd ? !rd_valid_q : wr_valid;
        default:         can_go = 1'b0;
      endcase
    end
  end

  // Points where the wait bit of a received byte is inspected
  assign decide    = eng_done && ((state == ST_POLL) ||
                                  (state == ST_HDR && idx[1:0] == 2'd3));
  assign wait_seen = decide && !eng_rx[0];
  assign bump      = wait_seen && !exhausted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cs_n_q     <= 1'b1;
      armed      <= 1'b0;
      idx        <= '0;
      lat_rd     <= 1'b0;
      lat_lm1    <= '0;
      lat_addr   <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (can_go) armed <= 1'b0;
      if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            lat_rd   <= cmd_read;
            lat_lm1  <= cmd_len_m1;
            lat_addr <= cmd_addr;
            cs_n_q   <= 1'b0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          idx   <= '0;
          armed <= 1'b1;
          state <= ST_HDR;
        end
        ST_HDR: begin
          if (eng_done) begin
            if (idx[1:0] != 2'd3) begin
              idx   <= idx + LEN_W'(1);
              armed <= 1'b1;
            end else if (eng_rx[0]) begin
              idx   <= '0;
              armed <= 1'b1;
              state <= ST_DATA;
            end else if (exhausted) begin
              state <= ST_ABORT;
            end else begin
              armed <= 1'b1;
              state <= ST_POLL;
            end
          end
        end
        ST_POLL: begin
          if (eng_done) begin
            if (eng_rx[0]) begin
              idx   <= '0;
              armed <= 1'b1;
              state <= ST_DATA;
            end else if (exhausted) begin
              state <= ST_ABORT;
            end else begin
              armed <= 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (eng_done) begin
            if (lat_rd) begin
              rd_data_q  <= eng_rx;
              rd_valid_q <= 1'b1;
            end
            if (idx == lat_lm1) begin
              state <= ST_FINISH;
            end else begin
              idx   <= idx + LEN_W'(1);
              armed <= 1'b1;
            end
          end
        end
        ST_FINISH: begin
          if (!rd_valid_q) begin
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: begin
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          err_q  <= 1'b1;
          state  <= ST_IDLE;
        end
      endcase
    end
  end

  spi_byte_engine #(.DIV_W(DIV_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .div       (clk_div),
    .start     (can_go),
    .tx_byte   (tx_sel),
    .miso      (spi_miso),
    .busy      (eng_busy),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .byte_done (eng_done),
    .rx_byte   (eng_rx)
  );

  spi_wait_budget #(.TMO_W(TMO_W)) u_budget (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .bump      (bump),
    .limit     (wait_limit),
    .exhausted (exhausted)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign wr_ready  = (state == ST_DATA) && !lat_rd && armed && !eng_busy;
  assign rd_data   = rd_data_q;
  assign rd_valid  = rd_valid_q;
  assign spi_cs_n  = cs_n_q;
  assign done      = done_q;
  assign error     = err_q;

  // R5
  cmd_ready_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_cs_n);
  // R5
  sclk_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R6
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> !spi_cs_n);
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R9
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tpm_spi_xact_test.sv
module tpm_spi_xact_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic [7:0]  wait_limit = 8'd0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_read = 1'b0;
  logic [5:0]  cmd_len_m1 = '0;
  logic [23:0] cmd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic        spi_sclk;
  logic        spi_cs_n;
  logic        spi_mosi;
  logic        spi_miso = 1'b1;
  logic        done;
  logic        error;

  tpm_spi_xact uut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .wait_limit(wait_limit),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_len_m1(cmd_len_m1), .cmd_addr(cmd_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .done(done), .error(error)
  );

  initial forever #5 clk = ~clk;

  // {backpressure, read, len-1, addr, stalls, limit, divider}
  localparam logic [55:0] VEC [10] = '{
    {1'b0, 1'b0, 6'd3,  24'hAABBCC, 8'd3, 8'd10, 8'd1},
    {1'b0, 1'b1, 6'd3,  24'hAABBCC, 8'd3, 8'd10, 8'd2},
    {1'b0, 1'b0, 6'd0,  24'h000001, 8'd0, 8'd4,  8'd3},
    {1'b1, 1'b1, 6'd0,  24'hFFFFFF, 8'd0, 8'd4,  8'd0},
    {1'b0, 1'b0, 6'd63, 24'h123456, 8'd1, 8'd8,  8'd1},
    {1'b1, 1'b1, 6'd63, 24'h00D40F, 8'd2, 8'd8,  8'd1},
    {1'b0, 1'b1, 6'd1,  24'h3C0F00, 8'd5, 8'd5,  8'd2},
    {1'b0, 1'b0, 6'd1,  24'h800080, 8'd6, 8'd5,  8'd1},
    {1'b0, 1'b1, 6'd0,  24'h000000, 8'd1, 8'd0,  8'd1},
    {1'b1, 1'b0, 6'd5,  24'h5A5A5A, 8'd2, 8'd3,  8'd4}
  };

  int checks = 0;
  int errors = 0;

  // current transaction, set by the main sequence
  int          cur_id = 0;
  logic        cur_bp = 1'b0;
  logic        cur_rd = 1'b0;
  int          cur_len = 0;
  logic [23:0] cur_addr = '0;
  int          cur_S = 0;

  function automatic logic [7:0] dat(input int i, input logic [23:0] a);
    dat = a[7:0] + 8'(i * 29) + 8'd7;
  endfunction

  // byte the peripheral model returns at position k of a frame
  function automatic logic [7:0] per_byte(input int k);
    if (k < 3)                per_byte = 8'hA5;
    else if (k < 3 + cur_S)   per_byte = 8'hFE;
    else if (k == 3 + cur_S)  per_byte = 8'h01;
    else                      per_byte = dat(k - 4 - cur_S, cur_addr ^ 24'h00FF00);
  endfunction

  // peripheral model: MISO changes on falling SCLK
  int bitn = 0;
  initial forever begin
    logic [7:0] pb;
    @(negedge spi_sclk or posedge spi_cs_n);
    if (spi_cs_n) bitn = 0;
    else bitn = bitn + 1;
    pb = per_byte(bitn / 8);
    spi_miso = pb[7 - (bitn % 8)];
  end

  // MOSI monitor: capture on rising SCLK
  int         nbits = 0;
  logic [7:0] mshift = '0;
  logic [7:0] mlog [400];
  initial forever begin
    @(posedge spi_sclk or negedge spi_cs_n);
    if (spi_sclk) begin
      mshift = {mshift[6:0], spi_mosi};
      nbits = nbits + 1;
      if (nbits % 8 == 0 && nbits / 8 <= 400) mlog[nbits/8 - 1] = mshift;
    end else begin
      nbits = 0;
    end
  end

  // stream drivers and SCLK timing measurement
  int         seen_id = 0;
  int         wi = 0;
  int         ri = 0;
  bit         wpend = 0;
  int         cyc = 0;
  logic [7:0] rlog [64];
  int         cs_rises = 0;
  logic       cs_prev = 1'b1;
  logic       sclk_prev = 1'b0;
  int         last_rise = -1;
  int         min_per = 1000000;
  int         hi_cnt = 0;
  int         hi_len = 0;
  initial forever begin
    @(negedge clk);
    cyc = cyc + 1;
    if (seen_id != cur_id) begin
      seen_id = cur_id; wi = 0; ri = 0; wpend = 0;
      cs_rises = 0; min_per = 1000000; last_rise = -1;
    end
    if (wpend) wi = wi + 1;
    wr_valid = !cur_rd && (wi < cur_len) && (cur_id > 0);
    wr_data  = dat(wi, cur_addr);
    wpend    = wr_valid && wr_ready;
    rd_ready = !cur_bp || (cyc % 3 == 0);
    if (rd_valid && rd_ready && ri < 64) begin
      rlog[ri] = rd_data;
      ri = ri + 1;
    end
    if (spi_cs_n && !cs_prev) cs_rises = cs_rises + 1;
    cs_prev = spi_cs_n;
    if (spi_sclk && !sclk_prev) begin
      if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
      last_rise = cyc;
      hi_cnt = 0;
    end
    if (spi_sclk) hi_cnt = hi_cnt + 1;
    if (!spi_sclk && sclk_prev) hi_len = hi_cnt;
    sclk_prev = spi_sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input int n);
    logic [55:0] v;
    int S, T, de, per, lo, npoll, nb, bad;
    bit abort, err_seen, got_done;
    logic [7:0] h0;
    v = VEC[n];
    @(negedge clk);
    cur_bp   = v[55];
    cur_rd   = v[54];
    cur_len  = int'(v[53:48]) + 1;
    cur_addr = v[47:24];
    cur_S    = int'(v[23:16]);
    T        = int'(v[15:8]);
    S        = cur_S;
    clk_div    = v[7:0];
    wait_limit = v[15:8];
    cmd_read   = v[54];
    cmd_len_m1 = v[53:48];
    cmd_addr   = v[47:24];
    cur_id     = cur_id + 1;
    cmd_valid  = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    // R5: accepted, engine busy, chip select low
    chk(!cmd_ready && !spi_cs_n, "R5 busy after accept", {cmd_ready, spi_cs_n}, 0);
    got_done = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done) begin got_done = 1; break; end
    end
    chk(got_done, "R9 done seen (watchdog)", got_done, 1);
    err_seen = error;
    @(negedge clk);
    @(negedge clk);
    chk(!done, "R9 done is one pulse", done, 0);
    chk(spi_cs_n && cs_rises == 1, "R5 single chip select release", cs_rises, 1);
    abort = (S > T);
    npoll = abort ? T : S;
    nb = 4 + npoll + (abort ? 0 : cur_len);
    chk(err_seen == abort, "R8 R9 error flag", err_seen, abort);
    chk(nbits == nb * 8, "R2 R3 R8 bytes on bus", nbits / 8, nb);
    h0 = {cur_rd, 1'b0, 6'(cur_len - 1)};
    chk(mlog[0] == h0, "R1 header byte one", mlog[0], h0);
    chk({mlog[1], mlog[2], mlog[3]} == cur_addr, "R1 address bytes",
        {mlog[1], mlog[2], mlog[3]}, cur_addr);
    bad = 0;
    for (int i = 0; i < npoll; i++) if (mlog[4 + i] != 8'h00) bad = bad + 1;
    chk(bad == 0, "R3 filler bytes are zero", bad, 0);
    if (!cur_rd) begin
      chk(wi == (abort ? 0 : cur_len), "R6 R8 write bytes taken", wi, abort ? 0 : cur_len);
      bad = 0;
      if (!abort)
        for (int i = 0; i < cur_len; i++)
          if (mlog[4 + npoll + i] != dat(i, cur_addr)) bad = bad + 1;
      chk(bad == 0, "R6 write data order", bad, 0);
    end else begin
      chk(ri == (abort ? 0 : cur_len), "R7 R8 read bytes delivered", ri, abort ? 0 : cur_len);
      bad = 0;
      if (!abort)
        for (int i = 0; i < cur_len; i++) begin
          if (rlog[i] != dat(i, cur_addr ^ 24'h00FF00)) bad = bad + 1;
          if (mlog[4 + npoll + i] != 8'h00) bad = bad + 1;
        end
      chk(bad == 0, "R7 read data order and zero MOSI", bad, 0);
    end
    de  = (v[7:0] == 0) ? 1 : int'(v[7:0]);
    per = de + 1;
    lo  = (de + 2) / 2;
    chk(min_per == per, "R4 SCLK period", min_per, per);
    chk(hi_len == per - lo, "R4 SCLK high time", hi_len, per - lo);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(spi_cs_n && !spi_sclk && cmd_ready, "R10 idle pins", {spi_cs_n, spi_sclk, cmd_ready}, 3'b101);
    chk(!done && !error && !rd_valid && !wr_ready, "R10 flags low",
        {done, error, rd_valid, wr_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_cs_n && cmd_ready && !spi_sclk, "R10 after reset release",
        {spi_cs_n, cmd_ready, spi_sclk}, 3'b110);
    for (int n = 0; n < 10; n++) run_vec(n);
    // idle after the table: no activity, ready for the next command
    repeat (5) @(negedge clk);
    chk(cmd_ready && spi_cs_n && !spi_sclk, "R5 idle between commands",
        {cmd_ready, spi_cs_n, spi_sclk}, 3'b110);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule